// File: doc/BRIEF.md
# Dual-Address Serial Configuration Target

This block is an I2C target that a host processor uses to configure an analog front end. It answers at two device addresses. The control address accepts register writes and reads. The readback address only supplies bytes from an external data source, such as a sliced-data buffer. A strap input sets the lowest address bit of both addresses at once. This lets two copies of the block share one bus.

On the control address, the first byte after the address byte selects a register subaddress. Each later byte written goes to the current subaddress, and the subaddress then steps by one. Reads return the byte at the current subaddress and step it in the same way. The register map holds three switch-select bytes and one output drive-strength byte. The switch-select fields are decoded into one one-hot input-selection vector per converter, and those vectors drive the analog switches. A global manual-enable bit gates all four vectors.

On the readback address, the block presents a byte index on a parallel port and returns the byte that arrives on the parallel data input. The SCL and SDA inputs pass through a two-flop synchroniser and a glitch filter before any edge is decoded. The block never stretches the clock.

Top module: `i2cdp_cfg_port`

## Requirements
- R1: With `strap_i`=0 the control port answers at 7-bit address 0x20 and the readback port at 0x10. With `strap_i`=1 they answer at 0x21 and 0x11. An address byte is the 7-bit address followed by the R/W bit (1 = read).
- R2: The block NACKs an address byte that matches neither port. It then ignores the bus until the next start condition, so later bytes change no register.
- R3: The block NACKs an address byte that selects the readback port with R/W=0 (a write).
- R4: In a control-port write, the first byte sets the subaddress. Each later byte is stored at the current subaddress, which then increments by one.
- R5: A control-port read returns the byte at the current subaddress and increments it after every byte. Subaddresses outside {0xC3, 0xC4, 0xF3, 0xF4} read as 0x00 and ignore writes.
- R6: After reset, registers 0xC3, 0xC4 and 0xF3 are 0x00, register 0xF4 is 0xD5, every switch vector is zero, and SDA is released.
- R7: `drive_o` always equals register 0xF4.
- R8: Register 0xC4 bit 7 enables manual switching (`mux_manual_o`). While this bit is 0, all switch vectors are zero, meaning no input is connected.
- R9: The switch codes for converters 0, 1 and 2 are 0xC3[3:0], 0xC3[7:4] and 0xC4[3:0]. Code k with 1 ≤ k ≤ NUM_IN sets bit k-1 of that converter's vector, which connects input k. Any other code sets no bit.
- R10: The switch code for converter 3 is 0xF3[7:4]. Code 0100 sets bit 5 (input 6), code 1001 sets bit 0 (input 1), and every other code sets no bit.
- R11: A read on the readback port returns `rb_data_i` for the index on `rb_addr_o`. The index starts at 0 in each transaction and steps by one after each byte.
- R12: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on the transfer.
- R13: When the controller NACKs a read byte, the block releases SDA and drives nothing more until the next start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_i | input | 1 | Sets the low address bit of both ports |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as sensed |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rb_addr_o | output | RB_AW | Byte index requested from the readback source |
| rb_data_i | input | 8 | Readback byte for `rb_addr_o` |
| mux_manual_o | output | 1 | Manual switching enable (0xC4 bit 7) |
| sw_sel_o | output | 4*NUM_IN | One-hot input selection, converter c at bits [c*NUM_IN +: NUM_IN] |
| drive_o | output | 8 | Output drive-strength setting |

## Verification
The bench builds the block with its defaults: FILT_LEN=3, NUM_IN=10 and RB_AW=8. With FILT_LEN=3, an injected two-cycle SCL pulse sits just below the acceptance threshold, so a filter that is off by one corrupts a stored byte. With NUM_IN=10, codes 11 to 15 and code 0 exercise the no-connection path for the linear converters, next to the two valid codes of converter 3. An 8-bit readback index lets the bench model the external source as a fixed XOR of the index and check each byte's position.

// File: rtl/i2cdp_pkg.sv
package i2cdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } bus_st_e;

  localparam int          NUM_CONV   = 4;
  localparam logic [5:0]  CTRL_ID_HI = 6'b010000;
  localparam logic [5:0]  RDBK_ID_HI = 6'b001000;
  localparam logic [7:0]  SUB_SEL_A  = 8'hC3;
  localparam logic [7:0]  SUB_SEL_B  = 8'hC4;
  localparam logic [7:0]  SUB_SEL_C  = 8'hF3;
  localparam logic [7:0]  SUB_DRIVE  = 8'hF4;
  localparam logic [7:0]  DRIVE_RST  = 8'hD5;
endpackage

// File: rtl/i2cdp_deglitch.sv
module i2cdp_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // a new level must persist FILT_LEN cycles before it is accepted
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) filt_d = sync_q[1];
      else                            cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  assert_filter_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q))
    else $error("filtered level changed to a value the synchroniser did not hold");
endmodule

// File: rtl/i2cdp_engine.sv
module i2cdp_engine
  import i2cdp_pkg::*;
#(
  parameter int RB_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             strap_i,
  input  logic [7:0]       ctrl_rdata,
  input  logic [7:0]       rb_data_i,
  output logic             sda_oe_o,
  output logic             wr_en,
  output logic [7:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic [7:0]       ctrl_raddr,
  output logic [RB_AW-1:0] rb_addr_o
);
  bus_st_e          st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       ptr_q, ptr_d;
  logic [RB_AW-1:0] rbp_q, rbp_d;
  logic             is_rb_q, is_rb_d, rnw_q, rnw_d, first_q, first_d;
  logic             oe_q, oe_d, nack_q, nack_d;
  logic             scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det, ctrl_hit, rb_hit;
  logic [7:0] tx_byte;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign ctrl_hit  = (sh_q[7:1] == {CTRL_ID_HI, strap_i});
  assign rb_hit    = (sh_q[7:1] == {RDBK_ID_HI, strap_i});
  assign tx_byte   = is_rb_q ? rb_data_i : ctrl_rdata;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; ptr_d = ptr_q; rbp_d = rbp_q;
    is_rb_d = is_rb_q; rnw_d = rnw_q; first_d = first_q; oe_d = oe_q; nack_d = nack_q;
    wr_en = 1'b0;
    if (start_det) begin
      st_d = ST_ADDR; cnt_d = '0; oe_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_f}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (ctrl_hit) begin
              oe_d = 1'b1; is_rb_d = 1'b0; rnw_d = sh_q[0]; st_d = ST_AACK;
            end else if (rb_hit && sh_q[0]) begin
              oe_d = 1'b1; is_rb_d = 1'b1; rnw_d = 1'b1; rbp_d = '0; st_d = ST_AACK;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rnw_q) begin
            st_d = ST_RDAT; sh_d = tx_byte; oe_d = ~tx_byte[7];
          end else begin
            st_d = ST_WDAT; oe_d = 1'b0; first_d = 1'b1;
          end
        end
        ST_WDAT: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_f}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            oe_d = 1'b1; st_d = ST_WACK;
            if (first_q) begin
              ptr_d = sh_q; first_d = 1'b0;
            end else begin
              wr_en = 1'b1; ptr_d = ptr_q + 8'd1;
            end
          end
        end
        ST_WACK: if (scl_fall) begin
          oe_d = 1'b0; cnt_d = '0; st_d = ST_WDAT;
        end
        ST_RDAT: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_d = 1'b0; st_d = ST_RACK;
              if (is_rb_q) rbp_d = rbp_q + 1'b1;
              else         ptr_d = ptr_q + 8'd1;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) nack_d = sda_f;
          else if (scl_fall) begin
            if (nack_q) st_d = ST_IDLE;
            else begin
              st_d = ST_RDAT; cnt_d = '0; sh_d = tx_byte; oe_d = ~tx_byte[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0; rbp_q <= '0;
      is_rb_q <= 1'b0; rnw_q <= 1'b0; first_q <= 1'b0; oe_q <= 1'b0; nack_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; ptr_q <= ptr_d; rbp_q <= rbp_d;
      is_rb_q <= is_rb_d; rnw_q <= rnw_d; first_q <= first_d; oe_q <= oe_d; nack_q <= nack_d;
      scl_q <= scl_f; sda_q <= sda_f;
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_addr    = ptr_q;
  assign wr_data    = sh_q;
  assign ctrl_raddr = ptr_q;
  assign rb_addr_o  = rbp_q;

  assert_rb_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_rb_q |-> !wr_en) else $error("register write during a readback transaction");
  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !oe_q) else $error("SDA still driven after a start condition");
  assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (oe_q && st_q == ST_WACK)) else $error("stored byte not acknowledged");
  assert_nack_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK && scl_fall && nack_q && !start_det && !stop_det) |=> (st_q == ST_IDLE && !oe_q))
    else $error("SDA not released after controller NACK");
endmodule

// File: rtl/i2cdp_cfgregs.sv
module i2cdp_cfgregs
  import i2cdp_pkg::*;
#(
  parameter int NUM_IN = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [7:0]                 waddr,
  input  logic [7:0]                 wdata,
  input  logic [7:0]                 raddr,
  output logic [7:0]                 rdata,
  output logic                       mux_en,
  output logic [NUM_CONV*NUM_IN-1:0] sw_sel,
  output logic [7:0]                 drive
);
  logic [7:0] sel_a_q, sel_a_d, sel_b_q, sel_b_d, sel_c_q, sel_c_d, drive_q, drive_d;
  logic [3:0] code [NUM_CONV];

  always_comb begin
    sel_a_d = sel_a_q; sel_b_d = sel_b_q; sel_c_d = sel_c_q; drive_d = drive_q;
    if (we) begin
      unique case (waddr)
        SUB_SEL_A: sel_a_d = wdata;
        SUB_SEL_B: sel_b_d = wdata;
        SUB_SEL_C: sel_c_d = wdata;
        SUB_DRIVE: drive_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q <= '0; sel_b_q <= '0; sel_c_q <= '0; drive_q <= DRIVE_RST;
    end else begin
      sel_a_q <= sel_a_d; sel_b_q <= sel_b_d; sel_c_q <= sel_c_d; drive_q <= drive_d;
    end
  end

  always_comb begin
    unique case (raddr)
      SUB_SEL_A: rdata = sel_a_q;
      SUB_SEL_B: rdata = sel_b_q;
      SUB_SEL_C: rdata = sel_c_q;
      SUB_DRIVE: rdata = drive_q;
      default:   rdata = 8'h00;
    endcase
  end

  assign code[0] = sel_a_q[3:0];
  assign code[1] = sel_a_q[7:4];
  assign code[2] = sel_b_q[3:0];
  assign code[3] = sel_c_q[7:4];
  assign mux_en  = sel_b_q[7];
  assign drive   = drive_q;

  for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
    logic [NUM_IN-1:0] hot;
    if (c == NUM_CONV - 1) begin : g_pair
      always_comb begin
        hot = '0;
        if (code[c] == 4'b0100)      hot[5] = 1'b1;
        else if (code[c] == 4'b1001) hot[0] = 1'b1;
      end
    end else begin : g_linear
      for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        assign hot[i] = ({28'd0, code[c]} == i + 1);
      end
    end
    assign sw_sel[c*NUM_IN +: NUM_IN] = mux_en ? hot : '0;

    assert_sw_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_sel[c*NUM_IN +: NUM_IN])) else $error("converter connects several inputs");
  end

  assert_drive_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(drive_q)) else $error("drive setting moved without a write");
endmodule

// File: rtl/i2cdp_cfg_port.sv
module i2cdp_cfg_port
  import i2cdp_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int NUM_IN   = 10,
  parameter int RB_AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strap_i,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe_o,
  output logic [RB_AW-1:0]           rb_addr_o,
  input  logic [7:0]                 rb_data_i,
  output logic                       mux_manual_o,
  output logic [NUM_CONV*NUM_IN-1:0] sw_sel_o,
  output logic [7:0]                 drive_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       scl_f, sda_f, wr_en;
  logic [7:0] wr_addr, wr_data, ctrl_raddr, ctrl_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  i2cdp_deglitch #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n_s), .raw_i(scl_i), .filt_o(scl_f));
  i2cdp_deglitch #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n_s), .raw_i(sda_i), .filt_o(sda_f));

  i2cdp_engine #(.RB_AW(RB_AW)) u_engine (
    .clk(clk), .rst_n(rst_n_s), .scl_f(scl_f), .sda_f(sda_f), .strap_i(strap_i),
    .ctrl_rdata(ctrl_rdata), .rb_data_i(rb_data_i), .sda_oe_o(sda_oe_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_raddr(ctrl_raddr), .rb_addr_o(rb_addr_o));

  i2cdp_cfgregs #(.NUM_IN(NUM_IN)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ctrl_raddr), .rdata(ctrl_rdata), .mux_en(mux_manual_o),
    .sw_sel(sw_sel_o), .drive(drive_o));
endmodule

// File: tb/i2cdp_cfg_port_bench.sv
module i2cdp_cfg_port_bench;
  localparam int Q = 12;
  localparam int H = 24;
  localparam int NI = 10;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, mux_man;
  logic [7:0] rb_addr, drive;
  logic [4*NI-1:0] sw;
  wire  sda_line = m_sda & ~sda_oe;
  wire [7:0] rb_data = rb_addr ^ 8'hA5;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2cdp_cfg_port u_i2cdp_cfg_port (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .rb_addr_o(rb_addr), .rb_data_i(rb_data),
    .mux_manual_o(mux_man), .sw_sel_o(sw), .drive_o(drive));

  // {subaddress, byte written, byte expected back}
  localparam logic [23:0] VEC [6] = '{
    {8'hC3, 8'h21, 8'h21}, {8'hC4, 8'h83, 8'h83}, {8'hF3, 8'h40, 8'h40},
    {8'hF4, 8'h3C, 8'h3C}, {8'h10, 8'hAA, 8'h00}, {8'hF4, 8'hD5, 8'hD5}};

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    m_sda = b; tick(4);
    if (glitch) begin m_scl = 1'b1; tick(2); m_scl = 1'b0; end
    tick(8); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2); b = sda_line; tick(H/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2); m_sda = 1'b0; tick(H/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H/2); m_sda = 1'b1; tick(H);
  endtask

  task automatic send(input logic [7:0] b, output logic ack, input bit glitch = 0);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitch && i == 7);
    get_bit(x); ack = ~x;
  endtask

  task automatic recv(output logic [7:0] b, input logic last);
    for (int i = 7; i >= 0; i--) get_bit(b[i]);
    put_bit(last, 1'b0);
  endtask

  function automatic logic [6:0] ctrl7(); return {6'b010000, strap}; endfunction

  task automatic wr_reg(input logic [7:0] sub, input logic [7:0] d, input bit glitch = 0);
    logic a;
    bus_start; send({ctrl7(), 1'b0}, a); send(sub, a); send(d, a, glitch); bus_stop;
  endtask

  task automatic rd_reg(input logic [7:0] sub, output logic [7:0] d);
    logic a;
    bus_start; send({ctrl7(), 1'b0}, a); send(sub, a);
    bus_start; send({ctrl7(), 1'b1}, a); recv(d, 1'b1); bus_stop;
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, d3;
    logic a;
    tick(5); rst_n = 1'b1; tick(5);
    // R6 reset state
    chk("R6 drive reset", drive, 8'hD5);
    chk("R6 switches reset", sw, '0);
    chk("R6 sda released", sda_oe, 1'b0);
    chk("R8 enable reset", mux_man, 1'b0);

    // R4 R5 write then read back each vector
    for (int k = 0; k < 6; k++) begin
      wr_reg(VEC[k][23:16], VEC[k][15:8]);
      rd_reg(VEC[k][23:16], d);
      chk($sformatf("R4/R5 sub %0h", VEC[k][23:16]), d, VEC[k][7:0]);
    end

    // R9 R10 decode with enable set (C3=21 C4=83 F3=40)
    chk("R8 enable on", mux_man, 1'b1);
    chk("R9 conv0 code1", sw[0*NI +: NI], 10'h001);
    chk("R9 conv1 code2", sw[1*NI +: NI], 10'h002);
    chk("R9 conv2 code3", sw[2*NI +: NI], 10'h004);
    chk("R10 conv3 code4", sw[3*NI +: NI], 10'h020);
    chk("R7 drive output", drive, 8'hD5);

    // R8 enable cleared
    wr_reg(8'hC4, 8'h03);
    chk("R8 all off", sw, '0);
    chk("R8 enable off", mux_man, 1'b0);

    wr_reg(8'hC4, 8'h8F); wr_reg(8'hC3, 8'hA0); wr_reg(8'hF3, 8'h90);
    chk("R9 conv0 code0 none", sw[0*NI +: NI], 10'h000);
    chk("R9 conv1 code10", sw[1*NI +: NI], 10'h200);
    chk("R9 conv2 code15 none", sw[2*NI +: NI], 10'h000);
    chk("R10 conv3 code9", sw[3*NI +: NI], 10'h001);
    wr_reg(8'hF3, 8'h50);
    chk("R10 conv3 code5 none", sw[3*NI +: NI], 10'h000);

    // R2 foreign address ignored
    bus_start; send({7'h30, 1'b0}, a);
    chk("R2 foreign nack", a, 1'b0);
    send(8'hF4, a); send(8'h00, a); bus_stop;
    chk("R2 no write", drive, 8'hD5);

    // R3 write to readback port
    bus_start; send({7'h10, 1'b0}, a); bus_stop;
    chk("R3 readback write nack", a, 1'b0);

    // R1 strap high
    strap = 1'b1;
    bus_start; send({7'h21, 1'b0}, a); send(8'hF4, a); send(8'h77, a); bus_stop;
    chk("R1 ctrl 0x21 ack", a, 1'b1);
    chk("R7 drive follows", drive, 8'h77);
    bus_start; send({7'h20, 1'b0}, a); bus_stop;
    chk("R1 0x20 nack with strap", a, 1'b0);
    bus_start; send({7'h11, 1'b1}, a); recv(d, 1'b1); bus_stop;
    chk("R1 readback 0x11 ack", a, 1'b1);
    chk("R11 readback byte0 strap1", d, 8'hA5);
    strap = 1'b0;

    // R11 readback stream
    bus_start; send({7'h10, 1'b1}, a);
    chk("R1 readback 0x10 ack", a, 1'b1);
    recv(d, 1'b0); recv(d2, 1'b0); recv(d3, 1'b1); bus_stop;
    chk("R11 byte0", d, 8'hA5);
    chk("R11 byte1", d2, 8'hA4);
    chk("R11 byte2", d3, 8'hA7);
    bus_start; send({7'h10, 1'b1}, a); recv(d, 1'b1); bus_stop;
    chk("R11 index restarts", d, 8'hA5);

    // R12 glitch on SCL during a data bit
    wr_reg(8'hF4, 8'h6B, 1);
    chk("R12 glitch rejected", drive, 8'h6B);

    // R5 multi-byte read with auto-increment, R13 release on NACK
    bus_start; send({ctrl7(), 1'b0}, a); send(8'hC3, a);
    bus_start; send({ctrl7(), 1'b1}, a); recv(d, 1'b0); recv(d2, 1'b1);
    chk("R13 released after nack", sda_oe, 1'b0);
    tick(20);
    chk("R13 still released", sda_oe, 1'b0);
    bus_stop;
    chk("R5 read C3", d, 8'hA0);
    chk("R5 read C4 incremented", d2, 8'h8F);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule